// File: doc/BRIEF.md
# Multiplexed LED Meter Scanner

This block drives a meter display of LEDs wired as a grid of 6 row lines by 16 column lines. Only one row is lit at any moment. The block steps through the rows quickly enough that every meter looks steadily lit. The row lines sink current, so a selected row is driven low. The column lines source current, so a lit column is driven high. In the intended wiring, nine 10-segment bargraphs and one single LED use 91 of the 96 crossings. The other crossings are simply never lit by the meter software.

A host fills the picture one 8-bit byte at a time. Each row takes two bytes. The bytes go into a hidden copy of the picture, which is kept apart from the copy being shown. The hidden copy becomes the shown copy only when the last row of a scan finishes. The display therefore never mixes an old picture with a new one.

Each row stays lit for a set number of clock cycles, chosen by a parameter. Between two rows there is a short dark gap, with every row and every column switched off, so that a lit pattern cannot smear into the next row.

Top module: `led_meter_scan`

## Requirements
- R1: While reset is held, and for BLANK_CYC cycles after it is released, every row output is high and every column output is low. The first row to light after reset is row 0, and it shows all columns off.
- R2: The host address is 2 × row + half. Half 0 loads columns 7..0 and half 1 loads columns 15..8, with the byte's bit k driving column k of that half.
- R3: A write to address 12, 13, 14 or 15 changes nothing on the display.
- R4: At most one row output is low at a time. Rows light in the order 0, 1, 2, 3, 4, 5 and then start again at 0.
- R5: Each row stays lit for exactly DWELL_CYC consecutive cycles in every scan.
- R6: Between any two lit rows there are exactly BLANK_CYC cycles in which all row outputs are high.
- R7: Writes reach the display only at a scan boundary. A scan shows one picture from its row 0 to its row 5, even if the host writes part-way through it.
- R8: A write made in the last lit cycle of row 5 is shown from the very next scan. A write made one cycle later is shown only from the scan after that.
- R9: Whenever no row is lit, every column output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one byte per cycle |
| wr_addr_i | input | ADDR_W (4) | Host byte address: 2 × row + half |
| wr_data_i | input | BYTE_W (8) | Host byte: column pattern for one half of a row |
| row_n_o | output | ROWS (6) | Row lines, low = row selected |
| col_o | output | COLS (16) | Column lines, high = LED lit |

## Verification
A host write and the hand-over from the hidden picture to the shown picture can fall in the same cycle. This happens in the last lit cycle of row 5. A write landing there must be in the next scan.

The bench finds the first lit cycle of row 5 at the row outputs. From that point it counts DWELL_CYC − 1 cycles. It then places a write to the low half of row 0 in exactly that cycle, and a write to the high half in the cycle after it.

The bench judges the result from row 0 of the next scan, which must show the first byte but not the second. It then checks the scan after that, which must show both bytes.

// File: rtl/led_scan_pkg.sv
// Package: led_scan_pkg
// Holds the scan phase type shared by the row sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package led_scan_pkg;

    // Dark gap between rows, or a row being lit
    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } scan_phase_e;

endpackage

// File: rtl/led_row_seq.sv
// Module: led_row_seq
// Steps the row index through 0..ROWS-1.
// Each row goes through a dark gap of BLANK_CYC cycles and then a lit
// period of DWELL_CYC cycles.
// swap_o is high in the last lit cycle of the last row. That is the only
// point where a new picture may be taken up.
// Assumes ROWS >= 2, DWELL_CYC >= 1 and BLANK_CYC >= 1.
// Reset is synchronous and active low. After reset the block sits at
// row 0, in the dark gap, with the counter cleared.
module led_row_seq
    import led_scan_pkg::*;
#(
    parameter int ROWS      = 6,
    parameter int DWELL_CYC = 2048,
    parameter int BLANK_CYC = 2,
    parameter int RW        = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [RW-1:0] row_o,
    output logic          lit_o,
    output logic          swap_o
);

    localparam int MAXC = (DWELL_CYC > BLANK_CYC) ? DWELL_CYC : BLANK_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    scan_phase_e   phase_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] row_q;
    logic          dark_end;
    logic          lit_end;
    logic          last_row;

    // End-of-period decodes for the current phase
    assign dark_end = (phase_q == PH_DARK) && (cnt_q == CW'(BLANK_CYC - 1));
    assign lit_end  = (phase_q == PH_LIT)  && (cnt_q == CW'(DWELL_CYC - 1));
    assign last_row = (row_q == RW'(ROWS - 1));

    // Phase, cycle counter and row index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DARK;
            cnt_q   <= '0;
            row_q   <= '0;
        end else if (dark_end) begin
            phase_q <= PH_LIT;
            cnt_q   <= '0;
        end else if (lit_end) begin
            phase_q <= PH_DARK;
            cnt_q   <= '0;
            row_q   <= last_row ? '0 : row_q + RW'(1);
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    assign row_o  = row_q;
    assign lit_o  = (phase_q == PH_LIT);
    assign swap_o = lit_end && last_row;

endmodule

// File: rtl/led_frame_store.sv
// Module: led_frame_store
// Holds two copies of the picture, each ROWS x COLS bits.
// The host fills the hidden copy one byte at a time. The byte at address
// a lands in row a/BPR, part a%BPR.
// On swap the shown copy takes the hidden copy, including any byte
// written in that same cycle.
// Addresses at or above ROWS*BPR match no byte, so a write there does
// nothing.
// Assumes COLS is a multiple of BYTE_W.
// Reset is synchronous and active low and clears both copies.
module led_frame_store #(
    parameter int ROWS   = 6,
    parameter int COLS   = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    parameter int RW     = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 swap,
    input  logic [RW-1:0]        rd_row,
    output logic [COLS-1:0]      rd_cols,
    output logic [ROWS*COLS-1:0] hidden_bits,
    output logic [ROWS*COLS-1:0] shown_bits
);

    localparam int BPR = COLS / BYTE_W;

    logic [ROWS-1:0][COLS-1:0] hidden_q;
    logic [ROWS-1:0][COLS-1:0] hidden_d;
    logic [ROWS-1:0][COLS-1:0] shown_q;

    // Next value of the hidden copy: each byte either takes the host
    // byte or keeps its old value
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar b = 0; b < BPR; b++) begin : g_byte
            logic hit;
            assign hit = wr_en && (wr_addr == ADDR_W'(r * BPR + b));
            assign hidden_d[r][b*BYTE_W +: BYTE_W] =
                hit ? wr_data : hidden_q[r][b*BYTE_W +: BYTE_W];
        end
    end

    // Register both copies; the shown copy changes only on swap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidden_q <= '0;
            shown_q  <= '0;
        end else begin
            hidden_q <= hidden_d;
            if (swap) begin
                shown_q <= hidden_d;
            end
        end
    end

    assign rd_cols     = shown_q[rd_row];
    assign hidden_bits = hidden_q;
    assign shown_bits  = shown_q;

endmodule

// File: rtl/led_row_drive.sv
// Module: led_row_drive
// Turns the row index and the lit flag into pin levels.
// The selected row is driven low and lit columns are driven high.
// While the lit flag is low, every row is high and every column is low.
// Assumes its inputs all come straight from registers, so the pins do
// not glitch.
module led_row_drive #(
    parameter int ROWS = 6,
    parameter int COLS = 16,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic            lit,
    input  logic [RW-1:0]   row,
    input  logic [COLS-1:0] cols,
    output logic [ROWS-1:0] row_n,
    output logic [COLS-1:0] col
);

    // One sink line for each row
    for (genvar r = 0; r < ROWS; r++) begin : g_sink
        assign row_n[r] = !(lit && (row == RW'(r)));
    end

    // Column lines are forced off during the dark gap
    assign col = lit ? cols : '0;

endmodule

// File: rtl/led_meter_scan.sv
// Module: led_meter_scan (top)
// Time-multiplexed scanner for a ROWS x COLS LED meter grid.
// A row sequencer sets the timing. A frame store with a hidden copy and
// a shown copy holds the picture. A pin stage drives the row and column
// lines.
// Assumes the host gives at most one byte per cycle.
// Reset is synchronous and active low.
module led_meter_scan #(
    parameter int ROWS      = 6,
    parameter int COLS      = 16,
    parameter int BYTE_W    = 8,
    parameter int DWELL_CYC = 2048,
    parameter int BLANK_CYC = 2,
    parameter int ADDR_W    = $clog2(ROWS * (COLS / BYTE_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [ROWS-1:0]   row_n_o,
    output logic [COLS-1:0]   col_o
);

    localparam int RW = $clog2(ROWS);

    logic [RW-1:0]        scan_row;
    logic                 scan_lit;
    logic                 frame_swap;
    logic [COLS-1:0]      row_cols;
    logic [ROWS*COLS-1:0] hidden_bits;
    logic [ROWS*COLS-1:0] shown_bits;

    led_row_seq #(
        .ROWS      (ROWS),
        .DWELL_CYC (DWELL_CYC),
        .BLANK_CYC (BLANK_CYC),
        .RW        (RW)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .row_o  (scan_row),
        .lit_o  (scan_lit),
        .swap_o (frame_swap)
    );

    led_frame_store #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .RW     (RW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en_i),
        .wr_addr     (wr_addr_i),
        .wr_data     (wr_data_i),
        .swap        (frame_swap),
        .rd_row      (scan_row),
        .rd_cols     (row_cols),
        .hidden_bits (hidden_bits),
        .shown_bits  (shown_bits)
    );

    led_row_drive #(
        .ROWS (ROWS),
        .COLS (COLS),
        .RW   (RW)
    ) u_drive (
        .lit   (scan_lit),
        .row   (scan_row),
        .cols  (row_cols),
        .row_n (row_n_o),
        .col   (col_o)
    );

endmodule

// File: rtl/led_meter_scan_chk.sv
// Module: led_meter_scan_chk
// Property checker bound into led_meter_scan.
// It watches the pins and the two picture copies.
// It assumes it is bound with the same parameter values as the top.
module led_meter_scan_chk #(
    parameter int ROWS      = 6,
    parameter int COLS      = 16,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int DWELL_CYC = 2048
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    wr_addr_i,
    input logic [ROWS-1:0]      row_n_o,
    input logic [COLS-1:0]      col_o,
    input logic                 frame_swap,
    input logic [ROWS*COLS-1:0] hidden_bits,
    input logic [ROWS*COLS-1:0] shown_bits
);

    localparam int LIMIT = ROWS * (COLS / BYTE_W);

    logic        row_on;
    logic [31:0] on_run;

    assign row_on = !(&row_n_o);

    // Length of the current lit run, read when the run ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_run <= '0;
        end else begin
            on_run <= row_on ? on_run + 32'd1 : 32'd0;
        end
    end

    // R4: never more than one row sunk at once
    p_one_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~row_n_o));

    // R9: columns are dark whenever no row is sunk
    p_dark_cols_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&row_n_o) |-> (col_o == '0));

    // R6: a lit row either stays the same row or goes dark next
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_on |=> (!row_on || $stable(row_n_o)));

    // R5: every lit run lasts exactly DWELL_CYC cycles
    p_dwell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_on) |-> (on_run == 32'(DWELL_CYC)));

    // R7: the shown picture moves only at a scan boundary
    p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_swap |=> $stable(shown_bits));

    // R3: writes beyond the last byte leave the hidden picture as it was
    p_bad_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (int'(wr_addr_i) >= LIMIT)) |=> $stable(hidden_bits));

endmodule

bind led_meter_scan led_meter_scan_chk #(
    .ROWS      (ROWS),
    .COLS      (COLS),
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W),
    .DWELL_CYC (DWELL_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .row_n_o     (row_n_o),
    .col_o       (col_o),
    .frame_swap  (frame_swap),
    .hidden_bits (hidden_bits),
    .shown_bits  (shown_bits)
);

// File: tb/led_meter_scan_bench.sv
// Bench for led_meter_scan.
// It mixes seeded random picture loads with directed corner cases.
// Expected pin levels come from a picture model inside the bench.
module led_meter_scan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 6;
    localparam int COLS       = 16;
    localparam int BYTE_W     = 8;
    localparam int DWELL      = 5;
    localparam int BLANK      = 2;
    localparam int ADDR_W     = 4;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en_i;
    logic [ADDR_W-1:0] wr_addr_i;
    logic [BYTE_W-1:0] wr_data_i;
    logic [ROWS-1:0]   row_n_o;
    logic [COLS-1:0]   col_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] hid_m  [ROWS][2];
    logic [7:0] show_m [ROWS][2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_meter_scan #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .BYTE_W    (BYTE_W),
        .DWELL_CYC (DWELL),
        .BLANK_CYC (BLANK),
        .ADDR_W    (ADDR_W)
    ) u_led_meter_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .row_n_o   (row_n_o),
        .col_o     (col_o)
    );

    // Row pin level expected when row r is selected (active low)
    function automatic logic [ROWS-1:0] row_pat(int r);
        return ~(ROWS'(1) << r);
    endfunction

    // Column pin level expected for row r of the shown picture
    function automatic logic [COLS-1:0] exp_cols(int r);
        return {show_m[r][1], show_m[r][0]};
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host write; called at a falling edge, returns at the next one
    task automatic host_write(int addr, logic [7:0] data);
        wr_en_i   = 1'b1;
        wr_addr_i = ADDR_W'(addr);
        wr_data_i = data;
        if (addr < ROWS * 2) hid_m[addr / 2][addr % 2] = data;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic wait_row(int r);
        while (row_n_o !== row_pat(r)) @(negedge clk);
    endtask

    // Wait until the current or next row 5 has ended; the picture moves then
    task automatic commit();
        wait_row(ROWS - 1);
        while (row_n_o === row_pat(ROWS - 1)) @(negedge clk);
        for (int r = 0; r < ROWS; r++) begin
            show_m[r][0] = hid_m[r][0];
            show_m[r][1] = hid_m[r][1];
        end
    endtask

    // Check one whole scan: row order, columns, lit length, gap
    task automatic scan_frame(string tag);
        int n;
        wait_row(0);
        for (int r = 0; r < ROWS; r++) begin
            check_eq("R4 row order", 32'(row_n_o), 32'(row_pat(r)));
            check_eq(tag, 32'(col_o), 32'(exp_cols(r)));
            n = 0;
            while (row_n_o === row_pat(r)) begin
                n++;
                @(negedge clk);
            end
            check_eq("R5 lit length", 32'(n), 32'(DWELL));
            check_eq("R9 columns dark in gap", 32'(col_o), 32'd0);
            n = 0;
            while (&row_n_o) begin
                n++;
                @(negedge clk);
            end
            check_eq("R6 gap length", 32'(n), 32'(BLANK));
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned rnd;
        rnd = $urandom(32'd4217);
        rst_n     = 1'b0;
        wr_en_i   = 1'b0;
        wr_addr_i = '0;
        wr_data_i = '0;
        for (int r = 0; r < ROWS; r++) begin
            hid_m[r][0] = '0; hid_m[r][1] = '0;
            show_m[r][0] = '0; show_m[r][1] = '0;
        end

        // R1: dark during reset and for BLANK cycles after it, then row 0
        repeat (3) @(negedge clk);
        check_eq("R1 rows in reset", 32'(row_n_o), 32'h3F);
        check_eq("R1 cols in reset", 32'(col_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 dark after release", 32'(row_n_o), 32'h3F);
        @(negedge clk);
        check_eq("R1 first row", 32'(row_n_o), 32'(row_pat(0)));
        check_eq("R1 first row columns", 32'(col_o), 32'd0);
        scan_frame("R1 reset picture");

        // R2: byte placement with a directed pattern
        for (int a = 0; a < ROWS * 2; a++) host_write(a, 8'(8'h11 * (a + 1)));
        commit();
        scan_frame("R2 byte placement");

        // R3: writes to addresses 12..15 do nothing
        for (int a = 12; a < 16; a++) host_write(a, 8'hA5);
        commit();
        scan_frame("R3 ignored addresses");

        // R2: random pictures, with random addresses that may be ignored
        for (int it = 0; it < 4; it++) begin
            int nw;
            nw = 10 + int'($urandom % 6);
            for (int k = 0; k < nw; k++) host_write(int'($urandom % 16), 8'($urandom));
            commit();
            scan_frame("R2 random picture");
        end

        // R7: a write during a scan must not show in that scan
        wait_row(1);
        host_write(8, ~show_m[4][0]);
        wait_row(4);
        check_eq("R7 no partial update", 32'(col_o), 32'(exp_cols(4)));
        commit();
        scan_frame("R7 picture after boundary");

        // R8: write in the last lit cycle of row 5, then one cycle later
        wait_row(ROWS - 1);
        repeat (DWELL - 1) @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = ~show_m[0][0];
        hid_m[0][0] = ~show_m[0][0];
        for (int r = 0; r < ROWS; r++) begin
            show_m[r][0] = hid_m[r][0];
            show_m[r][1] = hid_m[r][1];
        end
        @(negedge clk);
        wr_addr_i = 4'd1; wr_data_i = ~show_m[0][1];
        hid_m[0][1] = ~show_m[0][1];
        @(negedge clk);
        wr_en_i = 1'b0;
        wait_row(0);
        check_eq("R8 write in swap cycle shown next", 32'(col_o), 32'(exp_cols(0)));
        commit();
        scan_frame("R8 late write one scan later");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule